// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Register

This block is the digital front end of a 16-bit converter whose code arrives over an 8-bit bus. Two byte writes, steered by a byte-select line, fill a staging (input) register. A separate load strobe then copies the staged word into the output register that drives the converter. The output register therefore changes only on a load. Several such blocks can share one load strobe and update together.

The strobes come from a slow external bus and are treated as asynchronous. The bus lines pass through a two-stage synchroniser into a fast system clock domain, and every edge is detected there. The byte select is frozen when the write strobe falls. Holding write and load low together makes the selected byte transparent from the bus through to the output. A clear input with a level select forces both registers to zero or to midscale. A one-cycle pulse flags the start of each load, and a one-cycle flag marks each new output value.

Top module: `byte_dac_reg`

## Requirements
- R1: While the synchronised write strobe is low and the effective byte select is 0, `data_i` is written into bits 7:0 of the input register.
- R2: While the synchronised write strobe is low and the effective byte select is 1, `data_i` is written into bits 15:8 of the input register. Bits 7:0 keep their value.
- R3: The byte select is captured in the cycle the synchronised write strobe falls. Later changes of `bsel_i` while write stays low do not move the write to another byte. The data still lands in the byte captured at the fall.
- R4: While the synchronised load strobe is low, the output register takes the input register's value. Writes made with load high leave `dac_o` unchanged.
- R5: A low on `clr_ni` forces `dac_o` and the input register without waiting for a clock edge. The forced value is 0x0000 when `clr_lvl_i` is 0 and 0x8000 when it is 1. While clear is low, write and load pulses have no effect. Clear is released synchronously, two clock edges after `clr_ni` rises.
- R6: A low on `rst_ni` forces both registers to the same value that R5 selects from `clr_lvl_i`.
- R7: With write and load both low, the selected byte of the input register and of `dac_o` follow `data_i`. The other byte keeps its earlier value.
- R8: With write and load both high, `dac_o` stays constant whatever `data_i` and `bsel_i` do.
- R9: `upd_o` is high for exactly one cycle for each falling edge of the load strobe. It is high in the third cycle after load is driven low, which is the cycle in which the loaded value first shows on `dac_o`.
- R10: `valid_o` is high for exactly one cycle alongside each change of `dac_o` that comes from a load or from flow-through, and is low otherwise.
- R11: A strobe or data change driven before clock edge N takes effect at edge N+2. This is the latency of the two synchroniser stages plus the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Byte data bus |
| bsel_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_ni | input | 1 | Active-low write strobe |
| ld_ni | input | 1 | Active-low load strobe |
| clr_ni | input | 1 | Active-low asynchronous clear |
| clr_lvl_i | input | 1 | Clear value select: 0 zero, 1 midscale |
| dac_o | output | 16 | Output (converter) register |
| upd_o | output | 1 | One-cycle pulse at the start of a load |
| valid_o | output | 1 | One-cycle pulse with each new output value |

## Verification
The assertions assume that `clr_lvl_i` is static while clear or reset is applied. They also assume that `data_i` and `bsel_i` settle no later than the strobe edge they belong to, so that both cross the synchroniser in the same cycle. The stimulus sets `clr_lvl_i` before asserting clear or reset. It changes data, select and strobes only on falling clock edges, and holds each strobe level for at least three cycles so that every transition is seen after synchronisation. The sweep writes many distinct codes in two byte halves and checks each code after its load. Separate sequences cover the select lock, flow-through, idle buses and clear at both levels.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  typedef enum logic {
    CLR_ZERO = 1'b0,
    CLR_MID  = 1'b1
  } clr_lvl_e;

  typedef struct packed {
    logic wr_n;
    logic ld_n;
  } strobe_t;
endpackage

// File: rtl/bdr_sync.sv
module bdr_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{INIT}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/bdr_rst_gen.sv
// Asserts on either reset or clear at once; releases after STAGES edges.
module bdr_rst_gen #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic arst_no
);
  logic              any_n;
  logic [STAGES-1:0] sh_q;

  assign any_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge any_n) begin
    if (!any_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign arst_no = sh_q[STAGES-1];
endmodule

// File: rtl/byte_dac_reg.sv
module byte_dac_reg
  import bdr_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NB     = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DW-1:0]                   data_i,
  input  logic [((NB>1)?$clog2(NB):1)-1:0] bsel_i,
  input  logic                            wr_ni,
  input  logic                            ld_ni,
  input  logic                            clr_ni,
  input  logic                            clr_lvl_i,
  output logic [DW*NB-1:0]                dac_o,
  output logic                            upd_o,
  output logic                            valid_o
);
  localparam int unsigned OW = DW * NB;
  localparam int unsigned SW = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned XW = DW + SW + 2;
  localparam logic [OW-1:0] MID = {1'b1, {(OW-1){1'b0}}};
  localparam logic [XW-1:0] XINIT = {2'b11, {(SW+DW){1'b0}}};

  logic          arst_n;
  logic [XW-1:0] bus_s;
  strobe_t       stb_s;
  logic [SW-1:0] bsel_s;
  logic [DW-1:0] data_s;

  logic [OW-1:0] clr_val, in_q, in_nxt, out_q, out_nxt;
  logic          wr_q, ld_q, upd_q, vld_q;
  logic [SW-1:0] sel_q, sel_eff;
  logic          wr_fall, ld_fall;

  bdr_rst_gen #(.STAGES(STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .arst_no(arst_n)
  );

  // data and select cross with the strobes so they stay aligned
  bdr_sync #(.W(XW), .STAGES(STAGES), .INIT(XINIT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_ni, ld_ni, bsel_i, data_i}),
    .q_o   (bus_s)
  );

  assign stb_s  = strobe_t'(bus_s[XW-1 -: 2]);
  assign bsel_s = bus_s[DW +: SW];
  assign data_s = bus_s[DW-1:0];

  assign clr_val = (clr_lvl_e'(clr_lvl_i) == CLR_MID) ? MID : '0;

  assign wr_fall = wr_q & ~stb_s.wr_n;
  assign ld_fall = ld_q & ~stb_s.ld_n;
  assign sel_eff = wr_fall ? bsel_s : sel_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic we;
    assign we = ~stb_s.wr_n & (sel_eff == SW'(b));
    assign in_nxt[b*DW +: DW] = we ? data_s : in_q[b*DW +: DW];

    AST_SEL_LOCK: assert property (@(posedge clk_i) disable iff (!arst_n)
      (!stb_s.wr_n && !wr_q && bsel_s == SW'(b) && sel_q != SW'(b))
        |=> $stable(in_q[b*DW +: DW])) else $error("select lock"); // R3
  end

  assign out_nxt = stb_s.ld_n ? out_q : in_nxt;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      in_q  <= clr_val;
      out_q <= clr_val;
      wr_q  <= 1'b1;
      ld_q  <= 1'b1;
      sel_q <= '0;
      upd_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      in_q  <= in_nxt;
      out_q <= out_nxt;
      wr_q  <= stb_s.wr_n;
      ld_q  <= stb_s.ld_n;
      if (wr_fall) sel_q <= bsel_s;
      upd_q <= ld_fall;
      vld_q <= (out_nxt != out_q);
    end
  end

  assign dac_o   = out_q;
  assign upd_o   = upd_q;
  assign valid_o = vld_q;

  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!arst_n)
    upd_q |=> !upd_q) else $error("update pulse width"); // R9
  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!arst_n)
    stb_s.ld_n |=> $stable(out_q)) else $error("output moved without load"); // R4
  AST_VALID_CHG: assert property (@(posedge clk_i) disable iff (!arst_n)
    vld_q |-> (out_q != $past(out_q))) else $error("valid without change"); // R10
  AST_CLR_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arst_n |=> (out_q == $past(clr_val))) else $error("clear value"); // R5
endmodule

// File: tb/sim_byte_dac_reg.sv
module sim_byte_dac_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data = '0;
  logic [0:0]  bsel = '0;
  logic        wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, clr_lvl = 1'b1;
  logic [15:0] dac;
  logic        upd, vld;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [15:0] exp_dac;

  always #10 clk = ~clk;

  byte_dac_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .bsel_i(bsel),
    .wr_ni(wr_n), .ld_ni(ld_n), .clr_ni(clr_n), .clr_lvl_i(clr_lvl),
    .dac_o(dac), .upd_o(upd), .valid_o(vld)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic s, input logic [7:0] d);
    bsel = s; data = d; wr_n = 1'b0;
    wait_n(3);
    wr_n = 1'b1;
    wait_n(3);
  endtask

  // load with pulse timing checks; chg says whether dac_o should change
  task automatic do_load(input logic [15:0] exp, input bit chg);
    ld_n = 1'b0;
    wait_n(2);
    chk({15'd0, upd}, 16'd0, "R11 upd not before third edge");
    wait_n(1);
    chk({15'd0, upd}, 16'd1, "R9 upd pulse");
    chk({15'd0, vld}, {15'd0, chg}, "R10 valid with change");
    chk(dac, exp, "R4 load value");
    wait_n(1);
    chk({15'd0, upd}, 16'd0, "R9 upd one cycle");
    chk({15'd0, vld}, 16'd0, "R10 valid one cycle");
    ld_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R6 reset to midscale
    clr_lvl = 1'b1;
    wait_n(3);
    chk(dac, 16'h8000, "R6 reset midscale");
    chk({14'd0, upd, vld}, 16'd0, "R6 flags idle in reset");
    rst_n = 1'b1;
    wait_n(4);
    do_load(16'h8000, 1'b0);
    // R6 reset to zero
    clr_lvl = 1'b0;
    wait_n(1);
    rst_n = 1'b0;
    wait_n(2);
    chk(dac, 16'h0000, "R6 reset zero");
    rst_n = 1'b1;
    wait_n(4);
    exp_dac = 16'h0000;

    // R1 R2 R4 sweep over distinct codes
    for (int i = 0; i < 64; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h9E37) ^ 16'h5A5A;
      wr_byte(1'b0, v[7:0]);
      wr_byte(1'b1, v[15:8]);
      chk(dac, exp_dac, "R4 no change before load");
      do_load(v, 1'b1);
      exp_dac = v;
    end

    // R1 only low byte rewritten, high byte kept
    wr_byte(1'b0, 8'hC3);
    do_load({exp_dac[15:8], 8'hC3}, 1'b1);
    exp_dac = {exp_dac[15:8], 8'hC3};

    // R3 select captured at write fall, later change ignored
    bsel = 1'b0; data = 8'h11; wr_n = 1'b0;
    wait_n(3);
    bsel = 1'b1; data = 8'h7E;
    wait_n(3);
    wr_n = 1'b1;
    wait_n(3);
    do_load({exp_dac[15:8], 8'h7E}, 1'b1);
    exp_dac = {exp_dac[15:8], 8'h7E};

    // R3 a fresh write edge picks up the new select
    wr_byte(1'b1, 8'h2D);
    do_load({8'h2D, exp_dac[7:0]}, 1'b1);
    exp_dac = {8'h2D, exp_dac[7:0]};

    // R8 idle buses leave output alone
    for (int k = 0; k < 12; k++) begin
      data = 8'(k * 37); bsel = 1'(k);
      wait_n(1);
      chk(dac, exp_dac, "R8 idle hold");
      chk({14'd0, upd, vld}, 16'd0, "R8 idle flags");
    end
    wait_n(3);

    // R7 flow-through on the high byte
    bsel = 1'b1; data = 8'h01; wr_n = 1'b0; ld_n = 1'b0;
    wait_n(3);
    chk(dac, {8'h01, exp_dac[7:0]}, "R7 flow-through first");
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'(8'h40 + k * 19);
      data = d;
      wait_n(3);
      chk(dac, {d, exp_dac[7:0]}, "R7 flow-through follow");
    end
    exp_dac = {dac[15:8], exp_dac[7:0]};
    wr_n = 1'b1; ld_n = 1'b1;
    wait_n(3);
    data = 8'hFF;
    wait_n(4);
    chk(dac, exp_dac, "R7 hold after flow-through");

    // R5 clear to zero, strobes ignored, input register cleared too
    wr_byte(1'b0, 8'h34);
    wr_byte(1'b1, 8'h12);
    clr_lvl = 1'b0;
    wait_n(1);
    #2 clr_n = 1'b0;
    #1 chk(dac, 16'h0000, "R5 async clear zero");
    wait_n(1);
    bsel = 1'b0; data = 8'hAA; wr_n = 1'b0; ld_n = 1'b0;
    wait_n(4);
    chk(dac, 16'h0000, "R5 strobes ignored in clear");
    chk({14'd0, upd, vld}, 16'd0, "R5 no flags in clear");
    wr_n = 1'b1; ld_n = 1'b1;
    wait_n(3);
    clr_n = 1'b1;
    wait_n(4);
    do_load(16'h0000, 1'b0);

    // R5 clear to midscale
    wr_byte(1'b1, 8'h55);
    clr_lvl = 1'b1;
    wait_n(1);
    #3 clr_n = 1'b0;
    #1 chk(dac, 16'h8000, "R5 async clear midscale");
    wait_n(2);
    clr_n = 1'b1;
    wait_n(4);
    do_load(16'h8000, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule